// File: doc/BRIEF.md
# I2C Master Command and Receive Queue

This block sits between a host register port and the bit-level engine of an I2C master. The host queues command words, each holding a byte to send or a request to read one byte, with optional qualifiers that ask the engine to end the transfer with a stop or to open it with a repeated start. The engine takes entries from the head of the command queue through a valid/ready handshake. Every byte it receives from the bus goes into a separate receive queue. The host drains that queue by reading the data register.

Both queue levels can be read as registers. Two programmable thresholds produce a transmit-low flag and a receive-available flag, which an interrupt layer can use. Three one-cycle event outputs report a command dropped on a full queue, a read of an empty receive queue, and a received byte dropped on a full receive queue. An abort input, driven by the engine when a transfer fails, clears both queues in one cycle. Register address map (3-bit address): 0 is the data/command port, 1 is the transmit threshold, 2 is the receive threshold, 3 is the transmit level (read-only) and 4 is the receive level (read-only). Any other address reads as zero.

Top module: `i2c_cmd_queue`

## Requirements
- R1: A write to address 0 appends a command word to the transmit queue. The word carries the byte in bits 7:0, the read flag in bit 8, the stop flag in bit 9 and the restart flag in bit 10. `cmdValid` is high whenever that queue is non-empty. `cmdByte`, `cmdRead`, `cmdStop` and `cmdRestart` show the oldest entry. The entry leaves the queue on a clock edge where `cmdValid` and `cmdReady` are both high, and entries leave in the order they were written.
- R2: Reading address 3 returns the transmit queue level and reading address 4 returns the receive queue level, each in the range 0 to DEPTH. The value changes after the clock edge on which the queue was pushed or popped.
- R3: A command write to address 0 while the transmit queue holds DEPTH entries is discarded, even if the engine takes an entry in the same cycle. `txOverflow` is then high for exactly the cycle that follows.
- R4: Address 1 holds a read/write transmit threshold, reset value 0. `txEmptyFlag` is high whenever the transmit level is less than or equal to it.
- R5: Address 2 holds a read/write receive threshold, reset value 0. `rxFullFlag` is high whenever the receive level is greater than it, so a threshold of 0 raises the flag as soon as one byte is held.
- R6: A read of address 0 returns the oldest received byte in bits 7:0, with the upper bits zero, in the same cycle, and removes that byte at the clock edge.
- R7: A read of address 0 while the receive queue is empty returns zero and raises `rxUnderflow` for the following cycle. A byte arriving in that same cycle is still stored.
- R8: A byte presented on `rxValid`/`rxByte` while the receive queue holds DEPTH entries is discarded, even if the host reads in the same cycle. `rxOverflow` is then high for the following cycle, and the stored bytes are unchanged.
- R9: When `abort` is high at a clock edge, both queue levels are zero after that edge. Any command write, engine take, host pop or byte arrival in that cycle is discarded and raises no event. Threshold writes still take effect.
- R10: After reset both levels and both thresholds are zero, `cmdValid` and all event outputs are low, `txEmptyFlag` is high and `rxFullFlag` is low.
- R11: A push and a pop on the same queue in the same cycle both take effect, and the level stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops only at address 0) |
| regAddr | input | 3 | Register address |
| regWdata | input | REG_W | Register write data |
| regRdata | output | REG_W | Register read data, combinational from the address |
| cmdValid | output | 1 | Transmit queue holds an entry |
| cmdReady | input | 1 | Engine takes the head entry |
| cmdByte | output | 8 | Head entry data byte |
| cmdRead | output | 1 | Head entry is a read request |
| cmdStop | output | 1 | Head entry asks for a stop afterwards |
| cmdRestart | output | 1 | Head entry asks for a repeated start first |
| rxValid | input | 1 | Engine delivers a received byte |
| rxByte | input | 8 | Received byte |
| abort | input | 1 | Transfer aborted; clear both queues |
| txEmptyFlag | output | 1 | Transmit level at or below threshold |
| rxFullFlag | output | 1 | Receive level above threshold |
| txOverflow | output | 1 | One-cycle event: command dropped |
| rxUnderflow | output | 1 | One-cycle event: empty receive queue read |
| rxOverflow | output | 1 | One-cycle event: received byte dropped |

## Verification
The collisions of interest fall on a single edge. On the transmit queue, a host command write can meet an engine take. On the receive queue, a host pop can meet a byte arrival. Either pair can also land on a full or empty boundary or meet an abort. The bench provokes these in directed steps: writing into a full queue while the engine takes an entry, reading an empty queue while a byte arrives, and reading a full queue while a byte arrives. Random traffic then drives the pairs at high rates. Each outcome is judged against a queue model that decides overflow and underflow from the level before the edge, applies the pop before the push, and lets abort override both.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int CMD_W  = 11;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_TXTHR = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_RXTHR = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_TXLVL = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_RXLVL = 3'd4;

  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
    logic flush;
  } qStrobes_t;
endpackage

// File: rtl/cmdq_ring.sv
module cmdq_ring #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] headData,
  output logic [LVL_W-1:0] level
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      level <= level + LVL_W'(push) - LVL_W'(pop);
    end
  end

  assign headData = mem[rdPtr];
endmodule

// File: rtl/cmdq_datapath.sv
module cmdq_datapath import cmdq_pkg::*; #(
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  qStrobes_t        strobes,
  input  logic [CMD_W-1:0] cmdWord,
  input  logic [7:0]       rxByte,
  output logic [CMD_W-1:0] txHead,
  output logic [7:0]       rxHead,
  output logic [LVL_W-1:0] txLevel,
  output logic [LVL_W-1:0] rxLevel
);
  cmdq_ring #(.DEPTH(DEPTH), .WIDTH(CMD_W)) i_txRing (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (strobes.flush),
    .push     (strobes.txPush),
    .pop      (strobes.txPop),
    .wrData   (cmdWord),
    .headData (txHead),
    .level    (txLevel)
  );

  cmdq_ring #(.DEPTH(DEPTH), .WIDTH(8)) i_rxRing (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (strobes.flush),
    .push     (strobes.rxPush),
    .pop      (strobes.rxPop),
    .wrData   (rxByte),
    .headData (rxHead),
    .level    (rxLevel)
  );
endmodule

// File: rtl/cmdq_ctrl.sv
module cmdq_ctrl import cmdq_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int REG_W = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [LVL_W-1:0]  thrData,
  output logic [REG_W-1:0]  regRdata,
  input  logic              cmdReady,
  input  logic              rxValid,
  input  logic              abort,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic [7:0]        rxHead,
  output qStrobes_t         strobes,
  output logic              txEmptyFlag,
  output logic              rxFullFlag,
  output logic              txOverflow,
  output logic              rxUnderflow,
  output logic              rxOverflow
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [LVL_W-1:0] txThr, rxThr;
  logic dataWr, dataRd, txFull, rxFull, txEmpty, rxEmpty;

  assign dataWr  = regWrEn && (regAddr == ADDR_DATA);
  assign dataRd  = regRdEn && (regAddr == ADDR_DATA);
  assign txFull  = (txLevel == FULL_LVL);
  assign rxFull  = (rxLevel == FULL_LVL);
  assign txEmpty = (txLevel == '0);
  assign rxEmpty = (rxLevel == '0);

  always_comb begin
    strobes.flush  = abort;
    strobes.txPush = dataWr && !txFull && !abort;
    strobes.txPop  = cmdReady && !txEmpty && !abort;
    strobes.rxPush = rxValid && !rxFull && !abort;
    strobes.rxPop  = dataRd && !rxEmpty && !abort;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txThr       <= '0;
      rxThr       <= '0;
      txOverflow  <= 1'b0;
      rxUnderflow <= 1'b0;
      rxOverflow  <= 1'b0;
    end else begin
      if (regWrEn && regAddr == ADDR_TXTHR) txThr <= thrData;
      if (regWrEn && regAddr == ADDR_RXTHR) rxThr <= thrData;
      txOverflow  <= dataWr && txFull && !abort;
      rxUnderflow <= dataRd && rxEmpty && !abort;
      rxOverflow  <= rxValid && rxFull && !abort;
    end
  end

  assign txEmptyFlag = (txLevel <= txThr);
  assign rxFullFlag  = (rxLevel > rxThr);

  always_comb begin
    unique case (regAddr)
      ADDR_DATA:  regRdata = rxEmpty ? '0 : REG_W'(rxHead);
      ADDR_TXTHR: regRdata = REG_W'(txThr);
      ADDR_RXTHR: regRdata = REG_W'(rxThr);
      ADDR_TXLVL: regRdata = REG_W'(txLevel);
      ADDR_RXLVL: regRdata = REG_W'(rxLevel);
      default:    regRdata = '0;
    endcase
  end
endmodule

// File: rtl/i2c_cmd_queue.sv
module i2c_cmd_queue import cmdq_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int REG_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [7:0]        cmdByte,
  output logic              cmdRead,
  output logic              cmdStop,
  output logic              cmdRestart,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  input  logic              abort,
  output logic              txEmptyFlag,
  output logic              rxFullFlag,
  output logic              txOverflow,
  output logic              rxUnderflow,
  output logic              rxOverflow
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  qStrobes_t        strobes;
  logic [LVL_W-1:0] txLevel, rxLevel;
  logic [CMD_W-1:0] txHead;
  logic [7:0]       rxHead;
  logic             unusedBits;

  assign unusedBits = ^regWdata[REG_W-1:CMD_W];

  cmdq_ctrl #(.DEPTH(DEPTH), .REG_W(REG_W)) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regRdEn     (regRdEn),
    .regAddr     (regAddr),
    .thrData     (regWdata[LVL_W-1:0]),
    .regRdata    (regRdata),
    .cmdReady    (cmdReady),
    .rxValid     (rxValid),
    .abort       (abort),
    .txLevel     (txLevel),
    .rxLevel     (rxLevel),
    .rxHead      (rxHead),
    .strobes     (strobes),
    .txEmptyFlag (txEmptyFlag),
    .rxFullFlag  (rxFullFlag),
    .txOverflow  (txOverflow),
    .rxUnderflow (rxUnderflow),
    .rxOverflow  (rxOverflow)
  );

  cmdq_datapath #(.DEPTH(DEPTH)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .cmdWord (regWdata[CMD_W-1:0]),
    .rxByte  (rxByte),
    .txHead  (txHead),
    .rxHead  (rxHead),
    .txLevel (txLevel),
    .rxLevel (rxLevel)
  );

  assign cmdValid   = (txLevel != '0);
  assign cmdByte    = txHead[7:0];
  assign cmdRead    = txHead[8];
  assign cmdStop    = txHead[9];
  assign cmdRestart = txHead[10];
endmodule

// File: rtl/i2c_cmd_queue_chk.sv
module i2c_cmd_queue_chk #(
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic             regRdEn,
  input logic [2:0]       regAddr,
  input logic             cmdReady,
  input logic             rxValid,
  input logic             abort,
  input logic             txOverflow,
  input logic             rxUnderflow,
  input logic             rxOverflow,
  input logic [LVL_W-1:0] txLevel,
  input logic [LVL_W-1:0] rxLevel
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel <= FULL_LVL) && (rxLevel <= FULL_LVL));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 3'd0 && txLevel == FULL_LVL && !abort) |=> txOverflow);

  p_empty_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == 3'd0 && rxLevel == '0 && !abort && !rxValid)
      |=> (rxUnderflow && rxLevel == '0));

  p_rx_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxLevel == FULL_LVL && !abort && !(regRdEn && regAddr == 3'd0))
      |=> (rxOverflow && rxLevel == FULL_LVL));

  p_abort_flush_r9: assert property (@(posedge clk) disable iff (!rstN)
    abort |=> (txLevel == '0 && rxLevel == '0 && !txOverflow && !rxUnderflow && !rxOverflow));

  p_push_pop_r11: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 3'd0 && cmdReady && !abort && txLevel != '0 && txLevel != FULL_LVL)
      |=> $stable(txLevel));
endmodule

bind i2c_cmd_queue i2c_cmd_queue_chk #(.DEPTH(DEPTH)) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .regWrEn     (regWrEn),
  .regRdEn     (regRdEn),
  .regAddr     (regAddr),
  .cmdReady    (cmdReady),
  .rxValid     (rxValid),
  .abort       (abort),
  .txOverflow  (txOverflow),
  .rxUnderflow (rxUnderflow),
  .rxOverflow  (rxOverflow),
  .txLevel     (txLevel),
  .rxLevel     (rxLevel)
);

// File: tb/test_i2c_cmd_queue.sv
module test_i2c_cmd_queue;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int DEPTH = 8;
  localparam int REG_W = 16;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [REG_W-1:0] regWdata = '0;
  logic [REG_W-1:0] regRdata;
  logic cmdValid, cmdReady = 1'b0;
  logic [7:0] cmdByte;
  logic cmdRead, cmdStop, cmdRestart;
  logic rxValid = 1'b0;
  logic [7:0] rxByte = '0;
  logic abort = 1'b0;
  logic txEmptyFlag, rxFullFlag, txOverflow, rxUnderflow, rxOverflow;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [10:0] txQ[$];
  logic [7:0]  rxQ[$];
  int txThrM = 0;
  int rxThrM = 0;

  always #4 clk = ~clk;

  i2c_cmd_queue #(.DEPTH(DEPTH), .REG_W(REG_W)) i_i2c_cmd_queue (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdByte(cmdByte),
    .cmdRead(cmdRead), .cmdStop(cmdStop), .cmdRestart(cmdRestart),
    .rxValid(rxValid), .rxByte(rxByte), .abort(abort),
    .txEmptyFlag(txEmptyFlag), .rxFullFlag(rxFullFlag),
    .txOverflow(txOverflow), .rxUnderflow(rxUnderflow), .rxOverflow(rxOverflow)
  );

  function automatic bit expTxEmpty(int lvl, int thr);
    return lvl <= thr;
  endfunction

  function automatic bit expRxFull(int lvl, int thr);
    return lvl > thr;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idleInputs();
    regWrEn = 1'b0; regRdEn = 1'b0; cmdReady = 1'b0;
    rxValid = 1'b0; abort = 1'b0;
  endtask

  // Called just after a falling edge; ends just after the next falling edge.
  task automatic step(input bit wr, input logic [2:0] addr, input logic [15:0] wd,
                      input bit rd, input bit rdy, input bit rxv,
                      input logic [7:0] rxb, input bit ab);
    bit eTxO, eRxU, eRxO;
    eTxO = 0; eRxU = 0; eRxO = 0;
    idleInputs();
    regAddr = 3'd3; #1;
    check("R2 tx level", regRdata, txQ.size());
    regAddr = 3'd4; #1;
    check("R2 rx level", regRdata, rxQ.size());
    check("R4 txEmptyFlag", txEmptyFlag, expTxEmpty(txQ.size(), txThrM));
    check("R5 rxFullFlag", rxFullFlag, expRxFull(rxQ.size(), rxThrM));
    check("R1 cmdValid", cmdValid, txQ.size() != 0);
    if (txQ.size() != 0)
      check("R1 head entry", {cmdRestart, cmdStop, cmdRead, cmdByte}, txQ[0]);
    regWrEn = wr; regAddr = addr; regWdata = wd; regRdEn = rd;
    cmdReady = rdy; rxValid = rxv; rxByte = rxb; abort = ab;
    #1;
    if (rd && addr == 3'd0 && !ab) begin
      if (rxQ.size() != 0) check("R6 popped byte", regRdata, rxQ[0]);
      else                 check("R7 empty read value", regRdata, 0);
    end
    if (wr && addr == 3'd1) txThrM = int'(wd[LVL_W-1:0]);
    if (wr && addr == 3'd2) rxThrM = int'(wd[LVL_W-1:0]);
    if (ab) begin
      txQ.delete();
      rxQ.delete();
    end else begin
      eTxO = wr && addr == 3'd0 && txQ.size() == DEPTH;
      if (rdy && txQ.size() != 0) void'(txQ.pop_front());
      if (wr && addr == 3'd0 && !eTxO) txQ.push_back(wd[10:0]);
      eRxU = rd && addr == 3'd0 && rxQ.size() == 0;
      eRxO = rxv && rxQ.size() == DEPTH;
      if (rd && addr == 3'd0 && rxQ.size() != 0) void'(rxQ.pop_front());
      if (rxv && !eRxO) rxQ.push_back(rxb);
    end
    @(posedge clk);
    @(negedge clk);
    check(ab ? "R9 no txOverflow on abort" : "R3 txOverflow", txOverflow, eTxO);
    check(ab ? "R9 no rxUnderflow on abort" : "R7 rxUnderflow", rxUnderflow, eRxU);
    check(ab ? "R9 no rxOverflow on abort" : "R8 rxOverflow", rxOverflow, eRxO);
  endtask

  task automatic peek(input string tag, input logic [2:0] addr, input logic [31:0] exp);
    idleInputs();
    regAddr = addr; #1;
    check(tag, regRdata, exp);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired (all requirements)");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1c2a));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10: reset state
    check("R10 cmdValid after reset", cmdValid, 0);
    check("R10 txEmptyFlag after reset", txEmptyFlag, 1);
    check("R10 rxFullFlag after reset", rxFullFlag, 0);
    check("R10 events after reset", {txOverflow, rxUnderflow, rxOverflow}, 0);
    peek("R10 tx threshold after reset", 3'd1, 0);
    peek("R10 rx threshold after reset", 3'd2, 0);
    peek("R10 tx level after reset", 3'd3, 0);

    // R1/R3: fill command queue with mixed qualifiers, then overflow
    for (int i = 0; i < DEPTH; i++)
      step(1, 3'd0, 16'((i << 8) | (8'hA0 + i)), 0, 0, 0, 0, 0);
    step(1, 3'd0, 16'h0155, 0, 0, 0, 0, 0);  // dropped, R3
    step(1, 3'd0, 16'h0266, 0, 1, 0, 0, 0);  // full + take, still dropped (R3)
    peek("R3 level after full write with take", 3'd3, DEPTH - 1);
    // R11: push and take together mid-level
    step(1, 3'd0, 16'h0477, 0, 1, 0, 0, 0);
    peek("R11 tx level unchanged", 3'd3, DEPTH - 1);
    for (int i = 0; i < DEPTH; i++) step(0, 3'd0, 0, 0, 1, 0, 0, 0);

    // R4/R5 thresholds
    step(1, 3'd1, 16'd7, 0, 0, 0, 0, 0);
    peek("R4 tx threshold readback", 3'd1, 7);
    step(1, 3'd2, 16'd0, 0, 0, 0, 0, 0);
    step(0, 3'd0, 0, 0, 0, 1, 8'h3C, 0);
    check("R5 rxFullFlag with one byte, threshold 0", rxFullFlag, 1);

    // R6/R8: fill receive queue, overflow, read-with-arrival at full
    for (int i = 1; i < DEPTH; i++) step(0, 3'd0, 0, 0, 0, 1, 8'(8'h40 + i), 0);
    step(0, 3'd0, 0, 0, 0, 1, 8'hEE, 0);  // dropped, R8
    step(0, 3'd0, 0, 1, 0, 1, 8'hDD, 0);  // read + arrival at full: dropped
    peek("R8 rx level after read with drop", 3'd4, DEPTH - 1);
    for (int i = 0; i < DEPTH - 1; i++) step(0, 3'd0, 0, 1, 0, 0, 0, 0);

    // R7: empty read with simultaneous arrival
    step(0, 3'd0, 0, 1, 0, 1, 8'h99, 0);
    peek("R7 arrival kept on empty read", 3'd4, 1);
    peek("R7 stored byte", 3'd0, 8'h99);  // non-popping peek (rdEn low)

    // R9: abort with traffic in the same cycle
    step(1, 3'd0, 16'h0011, 0, 0, 0, 0, 0);
    step(1, 3'd0, 16'h0022, 1, 1, 1, 8'h12, 1);
    peek("R9 tx level after abort", 3'd3, 0);
    peek("R9 rx level after abort", 3'd4, 0);

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      automatic int r = int'($urandom_range(0, 99));
      automatic bit wr = ($urandom_range(0, 99) < 45);
      automatic logic [2:0] a = (r < 8) ? 3'd1 : (r < 16) ? 3'd2 : (r < 20) ? 3'd3 : 3'd0;
      automatic bit rd = ($urandom_range(0, 99) < 35);
      automatic bit rdy = ($urandom_range(0, 99) < 45);
      automatic bit rxv = ($urandom_range(0, 99) < 45);
      automatic bit ab = ($urandom_range(0, 199) == 0);
      automatic logic [15:0] wd = 16'($urandom);
      if (a == 3'd1 || a == 3'd2) wd = 16'($urandom_range(0, DEPTH + 1));
      step(wr, a, wd, rd, rdy, rxv, 8'($urandom), ab);
    end

    idleInputs();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule